// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned operands, one bit of the multiplier per clock, with a small adder in place of a full array. The datapath holds three registers: the multiplicand, the upper half of the running product, and a shared register. The shared register starts out holding the multiplier, and the low half of the product fills it as the multiplier bits are shifted out.

In each step, the bottom bit of the shared register chooses what goes into a multiplexer. When that bit is 1, the multiplexer takes the sum of the upper half and the multiplicand, one bit wider than an operand. When it is 0, it takes the upper half zero-extended to that width. The result is shifted right by one across the upper half and the shared register. The datapath takes only plain control lines: active-low loads for the multiplicand and upper-half registers, a two-bit mode code for the shared register, and sum-select and clear lines on the multiplexer. A small controller drives those lines.

A user pulses `start` with both operands present, waits for the one-cycle `done` pulse, and reads `product`. The product stays put until the next accepted start.

Top module: `shamul_top`

## Requirements
- R1: While reset (`rst_n` = 0) is held and after it is released, `product` reads 0 and `done` reads 0 until a start is accepted.
- R2: A start is accepted when `start` is 1 at a rising edge while the block is idle. `done` becomes 1 on the WIDTH-th rising edge after the accepting edge (the 8th for WIDTH = 8). It stays 1 for exactly one cycle.
- R3: While `done` is 1, `product` equals the unsigned product of the `mcand_in` and `mplier_in` values sampled at the accepting edge. This includes zero, all-ones and single-bit operands.
- R4: A `start` of 1 at any edge from the accepting edge up to and including the edge that ends the `done` cycle is ignored. It does not change the result or the timing of the operation under way.
- R5: From the cycle in which `done` is 1 until the next accepted start, `product` does not change.
- R6: The operand inputs are sampled only at the accepting edge. Changing them during the operation has no effect on the result.
- R7: The upper-half register is cleared at every accepted start. This holds when a new start is accepted in the first idle cycle right after `done`, with `start` held at 1 throughout.
- R8: The shared multiplier/low-product register follows its mode code: 2'b11 loads the multiplier, 2'b01 shifts right one place with the new top bit taken from bit 0 of the multiplexer output, and 2'b00 holds its contents.
- R9: In each shift step the upper half becomes bits [WIDTH:1] of the intermediate value. That value is (upper half + multiplicand) when the bottom bit of the shared register is 1, and the upper half alone when that bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication |
| mcand_in | input | WIDTH | Multiplicand operand |
| mplier_in | input | WIDTH | Multiplier operand |
| product | output | 2*WIDTH | Upper half and low half of the product |
| done | output | 1 | One-cycle pulse marking a valid product |

## Verification
The hardest case to reach is a start that lands exactly on the boundary between operations. A start during the `done` cycle must be ignored, while a start one cycle later must be accepted and must clear the leftover upper half. The stimulus reaches this boundary by holding `start` at 1 across two full operations. It also pulses `start` and changes both operands in the middle of a run, with different values. A per-clock behavioural model sets the exact cycle in which `done` must appear and the product that must be shown.

// File: rtl/shamul_pkg.sv
package shamul_pkg;
   typedef enum logic [1:0] {
      LP_HOLD  = 2'b00,
      LP_SHIFT = 2'b01,
      LP_SPARE = 2'b10,
      LP_LOAD  = 2'b11
   } lp_mode_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_RUN  = 2'b01,
      ST_FIN  = 2'b10
   } seq_state_t;
endpackage

// File: rtl/shamul_datapath.sv
module shamul_datapath
   import shamul_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit RIPPLE_ADD = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [WIDTH-1:0]   mcand_in,
   input  logic [WIDTH-1:0]   mplier_in,
   input  logic               ld_mc_n,
   input  logic               ld_hp_n,
   input  lp_mode_t           lp_mode,
   input  logic               sel_sum,
   input  logic               clr,
   output logic               lsb,
   output logic [2*WIDTH-1:0] prod
);
   localparam int FW = WIDTH + 1;

   initial begin
      if (WIDTH < 2) $error("shamul_datapath: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] mc_q, hp_q, lp_q;
   logic [FW-1:0]    sum_w, f_w;

   generate
      if (RIPPLE_ADD) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_w[i]  = hp_q[i] ^ mc_q[i] ^ cy[i];
            assign cy[i+1]   = (hp_q[i] & mc_q[i]) | (cy[i] & (hp_q[i] ^ mc_q[i]));
         end
         assign sum_w[WIDTH] = cy[WIDTH];
      end else begin : g_behav
         assign sum_w = {1'b0, hp_q} + {1'b0, mc_q};
      end
   endgenerate

   always_comb begin
      if (clr)          f_w = '0;
      else if (sel_sum) f_w = sum_w;
      else              f_w = {1'b0, hp_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mc_q <= '0;
      else if (!ld_mc_n) mc_q <= mcand_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hp_q <= '0;
      else if (!ld_hp_n) hp_q <= f_w[FW-1:1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lp_q <= '0;
      else begin
         case (lp_mode)
            LP_LOAD:  lp_q <= mplier_in;
            LP_SHIFT: lp_q <= {f_w[0], lp_q[WIDTH-1:1]};
            default:  lp_q <= lp_q;
         endcase
      end
   end

   assign lsb  = lp_q[0];
   assign prod = {hp_q, lp_q};

   // R8: mode code behaviour of the shared register
   assert_lp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_mode == LP_HOLD) |=> $stable(lp_q));
   assert_lp_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_mode == LP_LOAD) |=> (lp_q == $past(mplier_in)));
   assert_lp_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_mode == LP_SHIFT) |=> (lp_q[WIDTH-2:0] == $past(lp_q[WIDTH-1:1])));

   // R7: clear forces the upper half to zero
   assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !ld_hp_n) |=> (hp_q == '0));

   // R9: shift step adds the multiplicand only when the bottom bit was 1
   assert_step_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_hp_n && !clr && lp_mode == LP_SHIFT) |=>
      ({hp_q, lp_q[WIDTH-1]} == ({1'b0, $past(hp_q)} +
                                 ($past(lsb) ? {1'b0, $past(mc_q)} : {FW{1'b0}}))));

   // R6: multiplicand register only changes when its load is active
   assert_mc_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ld_mc_n |=> $stable(mc_q));
endmodule

// File: rtl/shamul_ctrl.sv
module shamul_ctrl
   import shamul_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     lsb,
   output logic     ld_mc_n,
   output logic     ld_hp_n,
   output lp_mode_t lp_mode,
   output logic     sel_sum,
   output logic     clr,
   output logic     done,
   output logic     idle
);
   localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

   seq_state_t       st_q, st_d;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      st_d    = st_q;
      ld_mc_n = 1'b1;
      ld_hp_n = 1'b1;
      lp_mode = LP_HOLD;
      sel_sum = 1'b0;
      clr     = 1'b0;
      done    = 1'b0;
      case (st_q)
         ST_IDLE: if (start) begin
            ld_mc_n = 1'b0;
            ld_hp_n = 1'b0;
            lp_mode = LP_LOAD;
            clr     = 1'b1;
            st_d    = ST_RUN;
         end
         ST_RUN: begin
            ld_hp_n = 1'b0;
            lp_mode = LP_SHIFT;
            sel_sum = lsb;
            if (cnt_q == LAST) st_d = ST_FIN;
         end
         ST_FIN: begin
            done = 1'b1;
            st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_RUN) cnt_q <= cnt_q + 1'b1;
         else                cnt_q <= '0;
      end
   end

   assign idle = (st_q == ST_IDLE);

   // R2: done lasts one cycle and is followed by idle
   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && idle));
   // R4: start is ignored outside idle
   assert_busy_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && start) |-> ld_mc_n);
endmodule

// File: rtl/shamul_top.sv
module shamul_top
   import shamul_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit RIPPLE_ADD = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [WIDTH-1:0]   mcand_in,
   input  logic [WIDTH-1:0]   mplier_in,
   output logic [2*WIDTH-1:0] product,
   output logic               done
);
   logic     ld_mc_n, ld_hp_n, sel_sum, clr, lsb, idle;
   lp_mode_t lp_mode;

   shamul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .lsb(lsb),
      .ld_mc_n(ld_mc_n), .ld_hp_n(ld_hp_n), .lp_mode(lp_mode),
      .sel_sum(sel_sum), .clr(clr), .done(done), .idle(idle)
   );

   shamul_datapath #(.WIDTH(WIDTH), .RIPPLE_ADD(RIPPLE_ADD)) u_dp (
      .clk(clk), .rst_n(rst_n), .mcand_in(mcand_in), .mplier_in(mplier_in),
      .ld_mc_n(ld_mc_n), .ld_hp_n(ld_hp_n), .lp_mode(lp_mode),
      .sel_sum(sel_sum), .clr(clr), .lsb(lsb), .prod(product)
   );

   // R5: product holds while idle without a start
   assert_hold_product_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !start) |=> $stable(product));
   // R1: no done pulse straight out of idle
   assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> !done);
endmodule

// File: tb/shamul_top_test.sv
module shamul_top_test;
   localparam int W = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [W-1:0]   mcand_in = '0;
   logic [W-1:0]   mplier_in = '0;
   logic [2*W-1:0] product;
   logic           done;

   int checks = 0;
   int failures = 0;
   string cur_req = "R1";

   int ph = 0;
   logic [2*W-1:0] exp_prod = '0;
   logic exp_done = 1'b0;
   int a_lat = 0, b_lat = 0;

   shamul_top #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mcand_in(mcand_in),
      .mplier_in(mplier_in), .product(product), .done(done)
   );

   always #5 clk = ~clk;

   // behavioural reference, one step per clock
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph = 0; exp_prod = '0; exp_done = 1'b0;
      end else if (ph == 0) begin
         exp_done = 1'b0;
         if (start) begin
            a_lat = int'(mcand_in); b_lat = int'(mplier_in); ph = 1;
         end
      end else if (ph < W) begin
         ph = ph + 1;
      end else if (ph == W) begin
         ph = W + 1; exp_done = 1'b1;
         exp_prod = (2*W)'(a_lat * b_lat);
      end else begin
         ph = 0; exp_done = 1'b0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (done !== exp_done) begin
            failures++;
            $display("FAIL R2 (%s) done=%0b expected=%0b", cur_req, done, exp_done);
         end
         if (ph == 0 || ph == W + 1) begin
            checks++;
            if (product !== exp_prod) begin
               failures++;
               $display("FAIL %s %s product=%h expected=%h", cur_req,
                        (ph == 0) ? "R5" : "R3", product, exp_prod);
            end
         end
      end
   end

   task automatic wait_idle();
      @(negedge clk);
      while (ph != 0) @(negedge clk);
   endtask

   task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      @(negedge clk);
      start = 1'b1; mcand_in = a; mplier_in = b;
      @(negedge clk);
      start = 1'b0;
      wait_idle();
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (product !== '0 || done !== 1'b0) begin
         failures++;
         $display("FAIL R1 product=%h done=%0b expected=0 0", product, done);
      end
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      cur_req = "R3 R8 R9 corners";
      run_mul(8'h00, 8'h00);
      run_mul(8'hFF, 8'hFF);
      run_mul(8'h00, 8'hFF);
      run_mul(8'hFF, 8'h00);
      run_mul(8'h01, 8'hFF);
      cur_req = "R3 R9 single-bit";
      for (int i = 0; i < W; i++)
         for (int j = 0; j < W; j += 3)
            run_mul(W'(1 << i), W'(1 << j));
      cur_req = "R3 R8 mixed";
      begin
         logic [15:0] lf = 16'hACE1;
         for (int k = 0; k < 30; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            run_mul(lf[7:0], lf[15:8]);
         end
      end

      // R4 and R6: start pulses and operand changes mid-run
      cur_req = "R4 R6";
      @(negedge clk);
      start = 1'b1; mcand_in = 8'hB7; mplier_in = 8'h5D;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      start = 1'b1; mcand_in = 8'h11; mplier_in = 8'h22;
      @(negedge clk);
      start = 1'b0; mcand_in = 8'hFF; mplier_in = 8'hFF;
      while (ph != W + 1) @(negedge clk);
      start = 1'b1; mcand_in = 8'h33;
      @(negedge clk);
      start = 1'b0;
      checks++;
      if (ph != 0) begin
         failures++;
         $display("FAIL R4 start in done cycle accepted: phase=%0d expected=0", ph);
      end
      repeat (4) @(negedge clk);
      checks++;
      if (product !== 16'(8'hB7 * 8'h5D)) begin
         failures++;
         $display("FAIL R4 product=%h expected=%h", product, 16'(8'hB7 * 8'h5D));
      end

      // R7: start held high across back-to-back operations
      cur_req = "R7";
      @(negedge clk);
      start = 1'b1; mcand_in = 8'hFF; mplier_in = 8'hFF;
      repeat (W + 2) @(negedge clk);
      mcand_in = 8'h03; mplier_in = 8'h05;
      wait_idle();
      start = 1'b0;
      wait_idle();
      repeat (2) @(negedge clk);
      checks++;
      if (product !== 16'd15) begin
         failures++;
         $display("FAIL R7 product=%h expected=%h", product, 16'd15);
      end

      cur_req = "R5 idle";
      mcand_in = 8'hAA; mplier_in = 8'h55;
      repeat (5) @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule